// File: doc/BRIEF.md
# Pointer Register Address Generator

This block turns three 16-bit pointer registers and an 11-bit stack pointer into data-memory and program-memory addresses. Each cycle in which the unit is idle it may accept one operation: a plain indirect access, an access that increments its pointer afterwards or decrements it beforehand, a pointer-plus-offset access, a stack push or pop, a 16-bit add or subtract of a small constant on a pointer, or a program-memory read through the Z pointer. The selected address, the new pointer value and the word-arithmetic flags are all registered on the edge that accepts the operation.

Every memory operation occupies the unit for two cycles and a program-memory read for three. While busy, the unit ignores further requests. A separate load port sets the pointer registers and the stack pointer. The memories themselves sit outside the block and consume `mem_addr` when `addr_valid` pulses.

Top module: `ptr_agu`

## Requirements
- R1: After reset X, Y and Z read 0, the stack pointer reads 0x7FF, `busy`, `addr_valid` and `wb_valid` are 0 and `flags` is 0.
- R2: A load with `wr_en` writes `wr_data` into the register picked by `wr_sel` (0 X, 1 Y, 2 Z, 3 stack pointer, low 11 bits), visible on the read ports after the edge. A load presented in a cycle that accepts an operation is dropped.
- R3: An operation is accepted on an edge where `start` is high, `busy` is low and the code is legal. `busy` is then high for exactly 2 cycles (3 for a program read). A `start` while busy changes no register and produces no address.
- R4: Code 1 (plain) issues the selected pointer (`ptr_sel` 0 X, 1 Y, 2 Z) as `mem_addr`. `addr_valid` is a one-cycle pulse after the accepting edge, and no register changes.
- R5: Code 2 issues the old pointer value and writes back the pointer plus 1, wrapping 0xFFFF to 0x0000. `wb_valid`, `wb_data` and `wb_sel` report the write-back.
- R6: Code 3 writes back the pointer minus 1, wrapping 0x0000 to 0xFFFF, and issues that new value as the address.
- R7: Code 4 issues Y or Z plus the unsigned 6-bit `disp` modulo 2^16 and writes nothing back. With `ptr_sel` 0 (X) or 3 the request is not accepted.
- R8: Code 5 (push) issues the stack pointer and then decrements it. Code 6 (pop) increments it first and issues the new value. Both wrap modulo 2^11 and report `wb_sel` = 3.
- R9: Code 7 adds and code 8 subtracts the unsigned 6-bit `imm` to or from the selected pointer modulo 2^16, with no address. `flags` is {S,V,N,Z,C} in bits 4..0: N is result bit 15, Z is result zero, C is carry out (add) or borrow (subtract). V is 1 when bit 15 rises 0→1 on add or falls 1→0 on subtract. S is N xor V. `flags` holds through all other codes.
- R10: Codes 9 and 10 issue Z as the address with `addr_prog` = 1, whatever `ptr_sel` is, and keep the unit busy 3 cycles. Code 10 also writes back Z plus 1.
- R11: Codes 0 and 11 to 15 are never accepted, and neither is `ptr_sel` 3 for codes 1, 2, 3, 7 and 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Load strobe for a pointer or the stack pointer |
| wr_sel | input | 2 | Load target: 0 X, 1 Y, 2 Z, 3 stack pointer |
| wr_data | input | 16 | Load value |
| start | input | 1 | Operation request |
| op | input | 4 | Operation code |
| ptr_sel | input | 2 | Pointer choice: 0 X, 1 Y, 2 Z |
| disp | input | 6 | Unsigned offset for code 4 |
| imm | input | 6 | Unsigned constant for codes 7 and 8 |
| busy | output | 1 | Unit occupied by an accepted operation |
| addr_valid | output | 1 | One-cycle pulse: `mem_addr` is fresh |
| addr_prog | output | 1 | Address targets program memory |
| mem_addr | output | 16 | Memory address |
| wb_valid | output | 1 | One-cycle pulse: a register was rewritten |
| wb_sel | output | 2 | Register rewritten: 0 X, 1 Y, 2 Z, 3 stack pointer |
| wb_data | output | 16 | New register value (stack pointer zero-extended) |
| flags | output | 5 | {S,V,N,Z,C} of the last word add or subtract |
| ptr_x | output | 16 | Current X |
| ptr_y | output | 16 | Current Y |
| ptr_z | output | 16 | Current Z |
| sp | output | 11 | Current stack pointer |

## Verification
The accepting edge updates every result together. The address, the write-back report, the flags and the new register contents are therefore checked half a cycle after that edge, and `addr_valid` is checked again one cycle later to confirm that it has fallen. `busy` is sampled at every falling edge until the cycle in which it must drop: two cycles after acceptance, or three for program reads. During the busy window a competing request is held for one cycle, and the registers are compared after it to show that it was ignored. For a rejected request, `busy` and `addr_valid` are checked to be low half a cycle after the edge on which it was presented.

// File: rtl/ptr_agu_pkg.sv
package ptr_agu_pkg;

   typedef enum logic [3:0] {
      OP_IDLE     = 4'd0,
      OP_PLAIN    = 4'd1,
      OP_POSTINC  = 4'd2,
      OP_PREDEC   = 4'd3,
      OP_DISP     = 4'd4,
      OP_PUSH     = 4'd5,
      OP_POP      = 4'd6,
      OP_ADDW     = 4'd7,
      OP_SUBW     = 4'd8,
      OP_PROG     = 4'd9,
      OP_PROG_INC = 4'd10
   } op_e;

   typedef enum logic [1:0] {
      SEL_X  = 2'd0,
      SEL_Y  = 2'd1,
      SEL_Z  = 2'd2,
      SEL_SP = 2'd3
   } sel_e;

   typedef struct packed {
      logic s;
      logic v;
      logic n;
      logic z;
      logic c;
   } flags_t;

endpackage

// File: rtl/ptr_agu_decode.sv
module ptr_agu_decode
   import ptr_agu_pkg::*;
#(
   parameter int MEM_LEN   = 2,
   parameter int PROG_LEN  = 3,
   parameter int CNT_W     = 2,
   parameter bit DISP_ON_X = 1'b0
) (
   input  logic             start_i,
   input  logic             idle_i,
   input  logic [3:0]       op_i,
   input  logic [1:0]       sel_i,
   output logic             accept_o,
   output logic [CNT_W-1:0] len_o
);

   logic disp_ok;
   logic ptr_ok;
   logic legal;

   assign ptr_ok = (sel_i != SEL_SP);

   generate
      if (DISP_ON_X) begin : g_disp_all
         assign disp_ok = ptr_ok;
      end else begin : g_disp_yz
         assign disp_ok = (sel_i == SEL_Y) || (sel_i == SEL_Z);
      end
   endgenerate

   always_comb begin
      legal = 1'b0;
      len_o = CNT_W'(MEM_LEN);
      case (op_e'(op_i))
         OP_PLAIN, OP_POSTINC, OP_PREDEC: legal = ptr_ok;
         OP_DISP:                         legal = disp_ok;
         OP_PUSH, OP_POP:                 legal = 1'b1;
         OP_ADDW, OP_SUBW:                legal = ptr_ok;
         OP_PROG, OP_PROG_INC: begin
            legal = 1'b1;
            len_o = CNT_W'(PROG_LEN);
         end
         default:                         legal = 1'b0;
      endcase
   end

   assign accept_o = start_i & idle_i & legal;

endmodule

// File: rtl/ptr_agu_wordalu.sv
module ptr_agu_wordalu
   import ptr_agu_pkg::*;
#(
   parameter int W   = 16,
   parameter int K_W = 6
) (
   input  logic [W-1:0]   a_i,
   input  logic [K_W-1:0] k_i,
   input  logic           sub_i,
   output logic [W-1:0]   r_o,
   output flags_t         flags_o
);

   logic [W-1:0] k_ext;
   logic [W:0]   sum;

   assign k_ext = {{(W-K_W){1'b0}}, k_i};

   always_comb begin
      if (sub_i) sum = {1'b0, a_i} - {1'b0, k_ext};
      else       sum = {1'b0, a_i} + {1'b0, k_ext};
      r_o       = sum[W-1:0];
      flags_o.c = sum[W];
      flags_o.n = sum[W-1];
      flags_o.z = (sum[W-1:0] == '0);
      flags_o.v = sub_i ? (a_i[W-1] & ~sum[W-1]) : (~a_i[W-1] & sum[W-1]);
      flags_o.s = flags_o.n ^ flags_o.v;
   end

endmodule

// File: rtl/ptr_agu_calc.sv
module ptr_agu_calc
   import ptr_agu_pkg::*;
#(
   parameter int PTR_W  = 16,
   parameter int SP_W   = 11,
   parameter int DISP_W = 6,
   parameter int IMM_W  = 6
) (
   input  logic [3:0]        op_i,
   input  logic [1:0]        sel_i,
   input  logic [PTR_W-1:0]  x_i,
   input  logic [PTR_W-1:0]  y_i,
   input  logic [PTR_W-1:0]  z_i,
   input  logic [SP_W-1:0]   sp_i,
   input  logic [DISP_W-1:0] disp_i,
   input  logic [IMM_W-1:0]  imm_i,
   output logic [PTR_W-1:0]  addr_o,
   output logic              addr_en_o,
   output logic              prog_o,
   output logic              wb_en_o,
   output logic [1:0]        wb_sel_o,
   output logic [PTR_W-1:0]  wb_data_o,
   output logic              flg_en_o,
   output flags_t            flags_o
);

   localparam int SP_PAD = PTR_W - SP_W;

   logic [PTR_W-1:0] base;
   logic [PTR_W-1:0] base_inc;
   logic [PTR_W-1:0] base_dec;
   logic [PTR_W-1:0] base_disp;
   logic [PTR_W-1:0] z_inc;
   logic [SP_W-1:0]  sp_inc;
   logic [SP_W-1:0]  sp_dec;
   logic [PTR_W-1:0] alu_r;
   logic             is_sub;

   always_comb begin
      case (sel_e'(sel_i))
         SEL_X:   base = x_i;
         SEL_Y:   base = y_i;
         SEL_Z:   base = z_i;
         default: base = {{SP_PAD{1'b0}}, sp_i};
      endcase
   end

   assign base_inc  = base + 1'b1;
   assign base_dec  = base - 1'b1;
   assign base_disp = base + {{(PTR_W-DISP_W){1'b0}}, disp_i};
   assign z_inc     = z_i + 1'b1;
   assign sp_inc    = sp_i + 1'b1;
   assign sp_dec    = sp_i - 1'b1;
   assign is_sub    = (op_i == OP_SUBW);

   ptr_agu_wordalu #(
      .W   (PTR_W),
      .K_W (IMM_W)
   ) u_alu (
      .a_i     (base),
      .k_i     (imm_i),
      .sub_i   (is_sub),
      .r_o     (alu_r),
      .flags_o (flags_o)
   );

   always_comb begin
      addr_o    = base;
      addr_en_o = 1'b0;
      prog_o    = 1'b0;
      wb_en_o   = 1'b0;
      wb_sel_o  = sel_i;
      wb_data_o = base;
      flg_en_o  = 1'b0;
      case (op_e'(op_i))
         OP_PLAIN: begin
            addr_en_o = 1'b1;
         end
         OP_POSTINC: begin
            addr_en_o = 1'b1;
            wb_en_o   = 1'b1;
            wb_data_o = base_inc;
         end
         OP_PREDEC: begin
            addr_o    = base_dec;
            addr_en_o = 1'b1;
            wb_en_o   = 1'b1;
            wb_data_o = base_dec;
         end
         OP_DISP: begin
            addr_o    = base_disp;
            addr_en_o = 1'b1;
         end
         OP_PUSH: begin
            addr_o    = {{SP_PAD{1'b0}}, sp_i};
            addr_en_o = 1'b1;
            wb_en_o   = 1'b1;
            wb_sel_o  = SEL_SP;
            wb_data_o = {{SP_PAD{1'b0}}, sp_dec};
         end
         OP_POP: begin
            addr_o    = {{SP_PAD{1'b0}}, sp_inc};
            addr_en_o = 1'b1;
            wb_en_o   = 1'b1;
            wb_sel_o  = SEL_SP;
            wb_data_o = {{SP_PAD{1'b0}}, sp_inc};
         end
         OP_ADDW, OP_SUBW: begin
            wb_en_o   = 1'b1;
            wb_data_o = alu_r;
            flg_en_o  = 1'b1;
         end
         OP_PROG: begin
            addr_o    = z_i;
            addr_en_o = 1'b1;
            prog_o    = 1'b1;
         end
         OP_PROG_INC: begin
            addr_o    = z_i;
            addr_en_o = 1'b1;
            prog_o    = 1'b1;
            wb_en_o   = 1'b1;
            wb_sel_o  = SEL_Z;
            wb_data_o = z_inc;
         end
         default: begin
            addr_en_o = 1'b0;
         end
      endcase
   end

endmodule

// File: rtl/ptr_agu_regs.sv
module ptr_agu_regs
   import ptr_agu_pkg::*;
#(
   parameter int PTR_W   = 16,
   parameter int SP_W    = 11,
   parameter int SP_INIT = 2047,
   parameter int N_PTR   = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             upd_en_i,
   input  logic [1:0]       upd_sel_i,
   input  logic [PTR_W-1:0] upd_data_i,
   input  logic             ld_en_i,
   input  logic [1:0]       ld_sel_i,
   input  logic [PTR_W-1:0] ld_data_i,
   output logic [PTR_W-1:0] ptr_o [N_PTR],
   output logic [SP_W-1:0]  sp_o
);

   generate
      for (genvar g = 0; g < N_PTR; g++) begin : g_ptr
         always_ff @(posedge clk) begin
            if (!rst_n)
               ptr_o[g] <= '0;
            else if (upd_en_i && upd_sel_i == 2'(g))
               ptr_o[g] <= upd_data_i;
            else if (ld_en_i && ld_sel_i == 2'(g))
               ptr_o[g] <= ld_data_i;
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)
         sp_o <= SP_W'(SP_INIT);
      else if (upd_en_i && upd_sel_i == SEL_SP)
         sp_o <= upd_data_i[SP_W-1:0];
      else if (ld_en_i && ld_sel_i == SEL_SP)
         sp_o <= ld_data_i[SP_W-1:0];
   end

   AST_SP_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
      (!(ld_en_i && ld_sel_i == SEL_SP) && !(upd_en_i && upd_sel_i == SEL_SP)) |=> $stable(sp_o))
      else $error("stack pointer moved without a request"); // R8

endmodule

// File: rtl/ptr_agu_seq.sv
module ptr_agu_seq #(
   parameter int CNT_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [CNT_W-1:0] len_i,
   output logic             busy_o
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load_i)
         cnt_q <= len_i;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign busy_o = (cnt_q != '0);

   AST_BUSY_TWO_MIN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |=> busy_o)
      else $error("busy window shorter than two cycles"); // R3

   AST_NO_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> !load_i)
      else $error("operation accepted while busy"); // R3

endmodule

// File: rtl/ptr_agu.sv
module ptr_agu
   import ptr_agu_pkg::*;
#(
   parameter int PTR_W     = 16,
   parameter int SP_W      = 11,
   parameter int DISP_W    = 6,
   parameter int IMM_W     = 6,
   parameter int MEM_LEN   = 2,
   parameter int PROG_LEN  = 3,
   parameter int SP_INIT   = 2047,
   parameter bit DISP_ON_X = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_sel,
   input  logic [PTR_W-1:0]  wr_data,
   input  logic              start,
   input  logic [3:0]        op,
   input  logic [1:0]        ptr_sel,
   input  logic [DISP_W-1:0] disp,
   input  logic [IMM_W-1:0]  imm,
   output logic              busy,
   output logic              addr_valid,
   output logic              addr_prog,
   output logic [PTR_W-1:0]  mem_addr,
   output logic              wb_valid,
   output logic [1:0]        wb_sel,
   output logic [PTR_W-1:0]  wb_data,
   output logic [4:0]        flags,
   output logic [PTR_W-1:0]  ptr_x,
   output logic [PTR_W-1:0]  ptr_y,
   output logic [PTR_W-1:0]  ptr_z,
   output logic [SP_W-1:0]   sp
);

   localparam int LEN_MAX = (MEM_LEN > PROG_LEN) ? MEM_LEN : PROG_LEN;
   localparam int CNT_W   = $clog2(LEN_MAX + 1);
   localparam int N_PTR   = 3;

   generate
      if (SP_W >= PTR_W || DISP_W >= PTR_W || IMM_W >= PTR_W) begin : g_bad_width
         $error("stack, offset and constant widths must be below the pointer width");
      end
      if (MEM_LEN < 2 || PROG_LEN < 2) begin : g_bad_len
         $error("operation lengths must be at least two cycles");
      end
      if (SP_INIT < 0 || SP_INIT >= (1 << SP_W)) begin : g_bad_init
         $error("stack pointer reset value does not fit");
      end
   endgenerate

   logic             accept;
   logic [CNT_W-1:0] len;
   logic             ld_go;
   logic [PTR_W-1:0] ptr_q [N_PTR];

   logic [PTR_W-1:0] c_addr;
   logic             c_addr_en;
   logic             c_prog;
   logic             c_wb_en;
   logic [1:0]       c_wb_sel;
   logic [PTR_W-1:0] c_wb_data;
   logic             c_flg_en;
   flags_t           c_flags;

   logic             addr_valid_q;
   logic             prog_q;
   logic [PTR_W-1:0] addr_q;
   logic             wb_valid_q;
   logic [1:0]       wb_sel_q;
   logic [PTR_W-1:0] wb_data_q;
   flags_t           flags_q;

   ptr_agu_decode #(
      .MEM_LEN   (MEM_LEN),
      .PROG_LEN  (PROG_LEN),
      .CNT_W     (CNT_W),
      .DISP_ON_X (DISP_ON_X)
   ) u_dec (
      .start_i  (start),
      .idle_i   (~busy),
      .op_i     (op),
      .sel_i    (ptr_sel),
      .accept_o (accept),
      .len_o    (len)
   );

   ptr_agu_seq #(
      .CNT_W (CNT_W)
   ) u_seq (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (accept),
      .len_i  (len),
      .busy_o (busy)
   );

   ptr_agu_calc #(
      .PTR_W  (PTR_W),
      .SP_W   (SP_W),
      .DISP_W (DISP_W),
      .IMM_W  (IMM_W)
   ) u_calc (
      .op_i      (op),
      .sel_i     (ptr_sel),
      .x_i       (ptr_q[0]),
      .y_i       (ptr_q[1]),
      .z_i       (ptr_q[2]),
      .sp_i      (sp),
      .disp_i    (disp),
      .imm_i     (imm),
      .addr_o    (c_addr),
      .addr_en_o (c_addr_en),
      .prog_o    (c_prog),
      .wb_en_o   (c_wb_en),
      .wb_sel_o  (c_wb_sel),
      .wb_data_o (c_wb_data),
      .flg_en_o  (c_flg_en),
      .flags_o   (c_flags)
   );

   assign ld_go = wr_en & ~accept;

   ptr_agu_regs #(
      .PTR_W   (PTR_W),
      .SP_W    (SP_W),
      .SP_INIT (SP_INIT),
      .N_PTR   (N_PTR)
   ) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .upd_en_i   (accept & c_wb_en),
      .upd_sel_i  (c_wb_sel),
      .upd_data_i (c_wb_data),
      .ld_en_i    (ld_go),
      .ld_sel_i   (wr_sel),
      .ld_data_i  (wr_data),
      .ptr_o      (ptr_q),
      .sp_o       (sp)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_valid_q <= 1'b0;
         prog_q       <= 1'b0;
         addr_q       <= '0;
         wb_valid_q   <= 1'b0;
         wb_sel_q     <= '0;
         wb_data_q    <= '0;
         flags_q      <= '0;
      end else begin
         addr_valid_q <= accept & c_addr_en;
         wb_valid_q   <= accept & c_wb_en;
         if (accept && c_addr_en) begin
            addr_q <= c_addr;
            prog_q <= c_prog;
         end
         if (accept && c_wb_en) begin
            wb_sel_q  <= c_wb_sel;
            wb_data_q <= c_wb_data;
         end
         if (accept && c_flg_en)
            flags_q <= c_flags;
      end
   end

   assign addr_valid = addr_valid_q;
   assign addr_prog  = prog_q;
   assign mem_addr   = addr_q;
   assign wb_valid   = wb_valid_q;
   assign wb_sel     = wb_sel_q;
   assign wb_data    = wb_data_q;
   assign flags      = flags_q;
   assign ptr_x      = ptr_q[0];
   assign ptr_y      = ptr_q[1];
   assign ptr_z      = ptr_q[2];

   AST_ADDR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      addr_valid |=> !addr_valid)
      else $error("address strobe longer than one cycle"); // R4

   AST_FROZEN_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !wr_en) |=> ($stable(ptr_x) && $stable(ptr_y) && $stable(ptr_z) && $stable(sp)))
      else $error("register changed during busy window"); // R3

   AST_WB_INSIDE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_valid || addr_valid) |-> busy)
      else $error("result strobe outside busy window"); // R3

   AST_DISP_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && op == OP_DISP) |=> (!wb_valid && $stable(ptr_y) && $stable(ptr_z)))
      else $error("offset access rewrote a pointer"); // R7

   AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(accept && (op == OP_ADDW || op == OP_SUBW)) |=> $stable(flags))
      else $error("flags moved without word arithmetic"); // R9

endmodule

// File: tb/sim_ptr_agu.sv
module sim_ptr_agu;

   localparam int CLK_T = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_sel = '0;
   logic [15:0] wr_data = '0;
   logic        start = 1'b0;
   logic [3:0]  op = '0;
   logic [1:0]  ptr_sel = '0;
   logic [5:0]  disp = '0;
   logic [5:0]  imm = '0;
   logic        busy, addr_valid, addr_prog, wb_valid;
   logic [15:0] mem_addr, wb_data, ptr_x, ptr_y, ptr_z;
   logic [1:0]  wb_sel;
   logic [4:0]  flags;
   logic [10:0] sp;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [31:0] mp [3];
   logic [31:0] msp;
   logic [4:0]  mflags;

   always #(CLK_T/2) clk = ~clk;

   ptr_agu u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .start(start), .op(op), .ptr_sel(ptr_sel), .disp(disp), .imm(imm),
      .busy(busy), .addr_valid(addr_valid), .addr_prog(addr_prog), .mem_addr(mem_addr),
      .wb_valid(wb_valid), .wb_sel(wb_sel), .wb_data(wb_data), .flags(flags),
      .ptr_x(ptr_x), .ptr_y(ptr_y), .ptr_z(ptr_z), .sp(sp)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic string tag_of(input int opc);
      case (opc)
         1: return "R4";
         2: return "R5";
         3: return "R6";
         4: return "R7";
         5, 6: return "R8";
         7, 8: return "R9";
         9, 10: return "R10";
         default: return "R11";
      endcase
   endfunction

   function automatic bit legal_of(input int opc, input int sel);
      case (opc)
         1, 2, 3, 7, 8: return sel < 3;
         4: return sel == 1 || sel == 2;
         5, 6, 9, 10: return 1'b1;
         default: return 1'b0;
      endcase
   endfunction

   task automatic check_regs(input string req);
      chk({req, " X"}, {16'h0, ptr_x}, mp[0]);
      chk({req, " Y"}, {16'h0, ptr_y}, mp[1]);
      chk({req, " Z"}, {16'h0, ptr_z}, mp[2]);
      chk({req, " SP"}, {21'h0, sp}, msp);
   endtask

   task automatic load_reg(input int sel, input logic [15:0] val);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = 2'(sel); wr_data = val;
      @(negedge clk);
      wr_en = 1'b0;
      if (sel == 3) msp = {16'h0, val} & 32'h7FF;
      else mp[sel] = {16'h0, val};
      check_regs("R2 load");
   endtask

   task automatic do_op(input int opc, input int sel, input int dv, input int iv,
                        input bit with_ld, input int ldsel, input logic [15:0] lddata);
      bit          lg;
      bit          exp_av, exp_prog, exp_wb;
      logic [31:0] base, exp_addr, exp_wbd, res;
      int          exp_wbs, len;
      string       t;
      t = tag_of(opc);
      lg = legal_of(opc, sel);
      base = (sel < 3) ? mp[sel] : msp;
      exp_av = 0; exp_prog = 0; exp_wb = 0; exp_addr = 0; exp_wbd = 0; exp_wbs = sel; len = 2;
      if (lg) begin
         case (opc)
            1: begin exp_av = 1; exp_addr = base; end
            2: begin exp_av = 1; exp_addr = base; exp_wb = 1; exp_wbd = (base + 1) & 32'hFFFF; end
            3: begin exp_av = 1; exp_addr = (base - 1) & 32'hFFFF; exp_wb = 1; exp_wbd = exp_addr; end
            4: begin exp_av = 1; exp_addr = (base + dv) & 32'hFFFF; end
            5: begin exp_av = 1; exp_addr = msp; exp_wb = 1; exp_wbs = 3; exp_wbd = (msp - 1) & 32'h7FF; end
            6: begin exp_wb = 1; exp_wbs = 3; exp_wbd = (msp + 1) & 32'h7FF; exp_av = 1; exp_addr = exp_wbd; end
            7, 8: begin
               exp_wb = 1;
               if (opc == 7) begin
                  res = base + iv;
                  mflags[0] = res[16];
                  exp_wbd = res & 32'hFFFF;
                  mflags[3] = ~base[15] & exp_wbd[15];
               end else begin
                  res = (base - iv) & 32'hFFFF;
                  mflags[0] = (iv > base);
                  exp_wbd = res;
                  mflags[3] = base[15] & ~exp_wbd[15];
               end
               mflags[2] = exp_wbd[15];
               mflags[1] = (exp_wbd == 0);
               mflags[4] = mflags[2] ^ mflags[3];
            end
            9: begin exp_av = 1; exp_prog = 1; exp_addr = mp[2]; len = 3; end
            10: begin exp_av = 1; exp_prog = 1; exp_addr = mp[2]; exp_wb = 1; exp_wbs = 2;
                      exp_wbd = (mp[2] + 1) & 32'hFFFF; len = 3; end
            default: ;
         endcase
      end
      @(negedge clk);
      start = 1'b1; op = 4'(opc); ptr_sel = 2'(sel); disp = 6'(dv); imm = 6'(iv);
      wr_en = with_ld; wr_sel = 2'(ldsel); wr_data = lddata;
      @(negedge clk);
      start = 1'b0; wr_en = 1'b0;
      if (exp_wb) begin
         if (exp_wbs == 3) msp = exp_wbd;
         else mp[exp_wbs] = exp_wbd;
      end
      if (!lg && with_ld) begin
         if (ldsel == 3) msp = {16'h0, lddata} & 32'h7FF;
         else mp[ldsel] = {16'h0, lddata};
      end
      chk({t, " busy after accept (R3)"}, {31'h0, busy}, {31'h0, lg});
      chk({t, " addr_valid"}, {31'h0, addr_valid}, {31'h0, exp_av});
      if (exp_av) begin
         chk({t, " mem_addr"}, {16'h0, mem_addr}, exp_addr);
         chk({t, " addr_prog"}, {31'h0, addr_prog}, {31'h0, exp_prog});
      end
      chk({t, " wb_valid"}, {31'h0, wb_valid}, {31'h0, exp_wb});
      if (exp_wb) begin
         chk({t, " wb_data"}, {16'h0, wb_data}, exp_wbd);
         chk({t, " wb_sel"}, {30'h0, wb_sel}, exp_wbs);
      end
      chk({t, " flags"}, {27'h0, flags}, {27'h0, mflags});
      check_regs(with_ld ? {t, " R2 load vs op"} : t);
      if (lg) begin
         start = 1'b1; op = 4'd2; ptr_sel = 2'd0;
         @(negedge clk);
         start = 1'b0;
         chk("R4 addr_valid falls", {31'h0, addr_valid}, 32'h0);
         chk("R3 busy second cycle", {31'h0, busy}, 32'h1);
         if (len == 3) begin
            @(negedge clk);
            chk("R10 busy third cycle", {31'h0, busy}, 32'h1);
         end
         @(negedge clk);
         chk("R3 busy released", {31'h0, busy}, 32'h0);
         chk("R3 start while busy ignored", {31'h0, addr_valid | wb_valid}, 32'h0);
         check_regs("R3 ignored start");
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd7321));
      mp[0] = 0; mp[1] = 0; mp[2] = 0; msp = 32'h7FF; mflags = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_regs("R1 reset");
      chk("R1 busy", {31'h0, busy}, 32'h0);
      chk("R1 addr_valid", {31'h0, addr_valid}, 32'h0);
      chk("R1 wb_valid", {31'h0, wb_valid}, 32'h0);
      chk("R1 flags", {27'h0, flags}, 32'h0);

      load_reg(0, 16'hFFFF);
      do_op(2, 0, 0, 0, 0, 0, 16'h0);          // R5 wrap
      load_reg(1, 16'h0000);
      do_op(3, 1, 0, 0, 0, 0, 16'h0);          // R6 wrap
      load_reg(1, 16'h1000);
      do_op(4, 1, 63, 0, 0, 0, 16'h0);         // R7 max offset
      load_reg(2, 16'hFFF0);
      do_op(4, 2, 32, 0, 0, 0, 16'h0);         // R7 wrap
      do_op(4, 0, 5, 0, 0, 0, 16'h0);          // R7 X rejected
      do_op(4, 3, 5, 0, 0, 0, 16'h0);          // R7 sel 3 rejected
      load_reg(3, 16'h0000);
      do_op(5, 0, 0, 0, 0, 0, 16'h0);          // R8 push wrap
      do_op(6, 0, 0, 0, 0, 0, 16'h0);          // R8 pop wrap
      load_reg(2, 16'h7FFF);
      do_op(7, 2, 0, 1, 0, 0, 16'h0);          // R9 overflow
      load_reg(1, 16'h0000);
      do_op(8, 1, 0, 1, 0, 0, 16'h0);          // R9 borrow
      load_reg(0, 16'h8000);
      do_op(8, 0, 0, 1, 0, 0, 16'h0);          // R9 signed overflow
      do_op(7, 0, 0, 0, 0, 0, 16'h0);          // R9 zero add
      do_op(10, 3, 0, 0, 0, 0, 16'h0);         // R10
      do_op(9, 1, 0, 0, 0, 0, 16'h0);          // R10
      do_op(12, 0, 0, 0, 0, 0, 16'h0);         // R11
      do_op(0, 1, 0, 0, 0, 0, 16'h0);          // R11
      do_op(1, 3, 0, 0, 0, 0, 16'h0);          // R11
      do_op(1, 0, 0, 0, 1, 1, 16'hABCD);       // R2 load dropped on accept
      do_op(15, 0, 0, 0, 1, 1, 16'h1234);      // R2 load kept on reject

      for (int n = 0; n < 400; n++) begin
         int opc, sel, dv, iv, ls;
         bit wl;
         opc = int'($urandom_range(0, 15));
         if ($urandom_range(0, 3) != 0) opc = int'($urandom_range(1, 10));
         sel = int'($urandom_range(0, 3));
         dv = int'($urandom_range(0, 63));
         iv = int'($urandom_range(0, 63));
         wl = ($urandom_range(0, 7) == 0);
         ls = int'($urandom_range(0, 3));
         if ($urandom_range(0, 5) == 0)
            load_reg(int'($urandom_range(0, 3)), 16'($urandom));
         do_op(opc, sel, dv, iv, wl, ls, 16'($urandom));
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule